// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single DMA channel that moves data between one peripheral and memory using two buffer slots, A and B. Each slot holds a start address and a byte count. While one slot is being transferred, software can refill the other one. When a slot runs out, the channel marks it done, drops its start flag and moves its buffer-in-use pointer to the other slot. If that slot is already started, transfer continues from it in the very next cycle.

Software reaches the channel through a word-indexed register window. The window holds the device attribute register, the two slot register pairs and a control-status register. The control-status register has one read address and two write addresses: at the set address a 1 bit sets the matching status bit, and at the clear address a 1 bit clears it. A 0 bit leaves the status bit unchanged. On the peripheral side the channel sees a request/acknowledge pair. On the memory side it drives a request with an address and a write flag, and it accepts a grant and a bus-error flag. A single interrupt line reports completion and errors.

Top module: `pdma_dual_slot`

## Requirements
- R1: After reset, every status bit, the attribute register, `irq_o` and `mem_req_o` read 0, and the buffer-in-use pointer selects slot A.
- R2: Status bits are: 0 run, 1 interrupt enable, 2 error, 3 done A, 4 start A, 5 done B, 6 start B, 7 buffer-in-use (0 = A, 1 = B). They read at word 3. A write to word 1 sets each status bit 0..6 whose data bit is 1. A write to word 2 clears each status bit 0..6 whose data bit is 1. Data bits that are 0 change nothing, and bit 7 ignores both writes.
- R3: The attribute register is word 0, 32 bits, and reads back as written. Its fields are: bit 0 direction (1 = device to memory), bit 1 big-endian, bit 2 burst of 8, bit 3 16-bit width, bits 7:4 peripheral select. `periph_addr_o` unpacks the device address as {attr[31:28], 6'b0, attr[27:8], 2'b00}.
- R4: Slot A uses words 4 (address) and 5 (count), and slot B uses words 6 and 7. Address bits 1:0 always read 0, and the count keeps 13 bits (writing 0xFFFF reads back 0x1FFF).
- R5: `mem_req_o` is high when run is set, the active slot's start bit is set, its count is nonzero and `dev_req_i` is high. A beat happens when `mem_gnt_i` is also high, and `dev_ack_o` is high in that same cycle. Each beat advances the slot address by the step and lowers the count by the step, stopping at 0. The step is 1 byte, or 2 bytes when attr bit 3 is set.
- R6: The beat that brings a slot's count to 0 finishes the slot. From the next cycle on, that slot's done bit is set, its start bit is clear and the buffer-in-use pointer has toggled.
- R7: If the other slot is already started when a slot finishes, its first beat comes in the cycle right after the last beat of the finished slot.
- R8: `irq_o` is high exactly while interrupt enable is set and at least one of error, done A or done B is set. Clearing those bits lowers it.
- R9: Clearing run stops requests and keeps the slot address, count and start bits. Setting run again resumes from the same address.
- R10: No request is made while run is clear, even with start bits set.
- R11: A beat that is granted while `mem_err_i` is high sets error and clears run from the next cycle on.
- R12: `mem_addr_o` is the active slot's current address, and `mem_we_o` equals attr bit 0.
- R13: A started slot whose count is 0 finishes without a beat, one cycle after run and start are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_word_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_word_i` |
| dev_req_i | input | 1 | Peripheral ready for a beat |
| dev_ack_o | output | 1 | Beat taken this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_gnt_i | input | 1 | Memory access granted |
| mem_err_i | input | 1 | Bus error on the granted access |
| mem_we_o | output | 1 | 1 = memory write |
| mem_addr_o | output | 32 | Memory address of the beat |
| periph_addr_o | output | 32 | Unpacked device address |
| irq_o | output | 1 | Interrupt |

## Verification
A wrong buffer-in-use pointer or a lost start bit shows on `mem_addr_o` in the first cycle after a slot finishes. In that cycle the address either jumps to the wrong base or requests stop. A count that is off by one step shows as one beat too many or too few, and the read-back count is nonzero after completion. Pause and error handling are checked by reading the slot registers back while the channel is halted, which shows whether any beat got through after run dropped.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int unsigned REG_W = 32;

  // word indexes in the register window
  localparam logic [2:0] W_ATTR  = 3'd0;
  localparam logic [2:0] W_SET   = 3'd1;
  localparam logic [2:0] W_CLR   = 3'd2;
  localparam logic [2:0] W_STAT  = 3'd3;
  localparam logic [2:0] W_A_ADR = 3'd4;
  localparam logic [2:0] W_A_CNT = 3'd5;
  localparam logic [2:0] W_B_ADR = 3'd6;
  localparam logic [2:0] W_B_CNT = 3'd7;

  // status bit positions; slot s uses DONE0 + 2*s and STRT0 + 2*s
  localparam int unsigned ST_RUN   = 0;
  localparam int unsigned ST_IE    = 1;
  localparam int unsigned ST_ERR   = 2;
  localparam int unsigned ST_DONE0 = 3;
  localparam int unsigned ST_STRT0 = 4;
  localparam int unsigned ST_BSEL  = 7;

  // attribute bits
  localparam int unsigned AT_DIR   = 0;
  localparam int unsigned AT_WIDE  = 3;
endpackage

// File: rtl/pdma_slot.sv
module pdma_slot #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adr_we_i,
  input  logic          cnt_we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          beat_i,
  input  logic [1:0]    step_i,
  output logic [AW-1:0] adr_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  assign last_o = (cnt_o <= CW'(step_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_o <= '0;
      cnt_o <= '0;
    end else begin
      if (adr_we_i)    adr_o <= {wdata_i[AW-1:2], 2'b00};
      else if (beat_i) adr_o <= adr_o + AW'(step_i);
      if (cnt_we_i)    cnt_o <= wdata_i[CW-1:0];
      else if (beat_i) cnt_o <= last_o ? '0 : cnt_o - CW'(step_i);
    end
  end
endmodule

// File: rtl/pdma_csr.sv
module pdma_csr
  import pdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_we_i,
  input  logic       clr_we_i,
  input  logic [6:0] wdata_i,
  input  logic       fin_i,
  input  logic       err_i,
  output logic [7:0] stat_o
);
  logic [7:0] nxt;

  // software first, hardware events override
  always_comb begin
    nxt = stat_o;
    if (set_we_i) nxt[6:0] = nxt[6:0] | wdata_i;
    if (clr_we_i) nxt[6:0] = nxt[6:0] & ~wdata_i;
    if (fin_i) begin
      if (stat_o[ST_BSEL]) begin
        nxt[ST_DONE0+2] = 1'b1;
        nxt[ST_STRT0+2] = 1'b0;
      end else begin
        nxt[ST_DONE0] = 1'b1;
        nxt[ST_STRT0] = 1'b0;
      end
      nxt[ST_BSEL] = ~stat_o[ST_BSEL];
    end
    if (err_i) begin
      nxt[ST_ERR] = 1'b1;
      nxt[ST_RUN] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= nxt;
  end
endmodule

// File: rtl/pdma_dual_slot.sv
module pdma_dual_slot
  import pdma_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_word_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             dev_req_i,
  output logic             dev_ack_o,
  output logic             mem_req_o,
  input  logic             mem_gnt_i,
  input  logic             mem_err_i,
  output logic             mem_we_o,
  output logic [REG_W-1:0] mem_addr_o,
  output logic [REG_W-1:0] periph_addr_o,
  output logic             irq_o
);
  localparam int unsigned NSLOT = 2;

  logic [REG_W-1:0]            attr_q;
  logic [7:0]                  stat_q;
  logic [NSLOT-1:0][REG_W-1:0] slot_adr;
  logic [NSLOT-1:0][CNT_W-1:0] slot_cnt;
  logic [NSLOT-1:0]            slot_last;
  logic [1:0]                  step;
  logic                        act, live, cnt_zero, beat, fin, err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             attr_q <= '0;
    else if (reg_we_i && reg_word_i == W_ATTR) attr_q <= reg_wdata_i;
  end

  assign step     = attr_q[AT_WIDE] ? 2'd2 : 2'd1;
  assign act      = stat_q[ST_BSEL];
  assign live     = stat_q[ST_RUN] & stat_q[ST_STRT0 + 2*act];
  assign cnt_zero = (slot_cnt[act] == '0);
  assign mem_req_o = live & ~cnt_zero & dev_req_i;
  assign beat      = mem_req_o & mem_gnt_i;
  assign dev_ack_o = beat;
  assign fin       = live & (cnt_zero | (beat & slot_last[act]));
  assign err       = beat & mem_err_i;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    pdma_slot #(.AW(REG_W), .CW(CNT_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adr_we_i (reg_we_i && reg_word_i == W_A_ADR + 3'(2*s)),
      .cnt_we_i (reg_we_i && reg_word_i == W_A_CNT + 3'(2*s)),
      .wdata_i  (reg_wdata_i),
      .beat_i   (beat && (act == 1'(s))),
      .step_i   (step),
      .adr_o    (slot_adr[s]),
      .cnt_o    (slot_cnt[s]),
      .last_o   (slot_last[s])
    );
  end

  pdma_csr u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (reg_we_i && reg_word_i == W_SET),
    .clr_we_i (reg_we_i && reg_word_i == W_CLR),
    .wdata_i  (reg_wdata_i[6:0]),
    .fin_i    (fin),
    .err_i    (err),
    .stat_o   (stat_q)
  );

  assign mem_addr_o    = slot_adr[act];
  assign mem_we_o      = attr_q[AT_DIR];
  assign periph_addr_o = {attr_q[31:28], 6'b0, attr_q[27:8], 2'b00};
  assign irq_o = stat_q[ST_IE] & (stat_q[ST_ERR] | stat_q[ST_DONE0] | stat_q[ST_DONE0+2]);

  always_comb begin
    unique case (reg_word_i)
      W_ATTR:  reg_rdata_o = attr_q;
      W_A_ADR: reg_rdata_o = slot_adr[0];
      W_A_CNT: reg_rdata_o = REG_W'(slot_cnt[0]);
      W_B_ADR: reg_rdata_o = slot_adr[1];
      W_B_CNT: reg_rdata_o = REG_W'(slot_cnt[1]);
      default: reg_rdata_o = REG_W'(stat_q);
    endcase
  end
endmodule

// File: rtl/pdma_dual_slot_chk.sv
module pdma_dual_slot_chk #(
  parameter int unsigned CNT_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       stat_i,
  input logic             mem_req_i,
  input logic             mem_gnt_i,
  input logic             mem_err_i,
  input logic             dev_ack_i,
  input logic             irq_i,
  input logic             reg_we_i,
  input logic             fin_i,
  input logic [CNT_W-1:0] cnt_a_i,
  input logic [CNT_W-1:0] cnt_b_i
);
  assert_req_needs_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> stat_i[0]);

  assert_ack_granted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ack_i |-> (mem_req_i && mem_gnt_i));

  assert_bsel_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (stat_i[7] != $past(stat_i[7])));

  assert_done_a_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !stat_i[7]) |=> (stat_i[3] && !stat_i[4]));

  assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_ack_i && !reg_we_i) |=> ($stable(cnt_a_i) && $stable(cnt_b_i)));

  assert_irq_on_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stat_i[3]) && stat_i[1]) |-> irq_i);

  assert_err_stops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_ack_i && mem_err_i) |=> (!stat_i[0] && stat_i[2]));
endmodule

bind pdma_dual_slot pdma_dual_slot_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stat_i    (stat_q),
  .mem_req_i (mem_req_o),
  .mem_gnt_i (mem_gnt_i),
  .mem_err_i (mem_err_i),
  .dev_ack_i (dev_ack_o),
  .irq_i     (irq_o),
  .reg_we_i  (reg_we_i),
  .fin_i     (fin),
  .cnt_a_i   (slot_cnt[0]),
  .cnt_b_i   (slot_cnt[1])
);

// File: tb/pdma_dual_slot_test.sv
module pdma_dual_slot_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_word_i = 3'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dev_req_i = 1'b0;
  logic        dev_ack_o;
  logic        mem_req_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_err_i = 1'b0;
  logic        mem_we_o;
  logic [31:0] mem_addr_o;
  logic [31:0] periph_addr_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk_i = ~clk_i;

  pdma_dual_slot uut (
    .clk_i, .rst_ni, .reg_we_i, .reg_word_i, .reg_wdata_i, .reg_rdata_o,
    .dev_req_i, .dev_ack_o, .mem_req_o, .mem_gnt_i, .mem_err_i,
    .mem_we_o, .mem_addr_o, .periph_addr_o, .irq_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    reg_we_i = 1'b1; reg_word_i = w; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    reg_word_i = w;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd3, v); chk("R1 status", v, 32'h0);
    rd(3'd0, v); chk("R1 attr", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 req", {31'b0, mem_req_o}, 32'h0);
  endtask

  task automatic t_csr();
    logic [31:0] v;
    wr(3'd1, 32'h02); rd(3'd3, v); chk("R2 set ie", v, 32'h02);
    wr(3'd1, 32'h00); rd(3'd3, v); chk("R2 set zero", v, 32'h02);
    wr(3'd1, 32'h80); rd(3'd3, v); chk("R2 bit7 set ignored", v, 32'h02);
    wr(3'd2, 32'h00); rd(3'd3, v); chk("R2 clear zero", v, 32'h02);
    wr(3'd2, 32'hFF); rd(3'd3, v); chk("R2 clear all", v, 32'h00);
  endtask

  task automatic t_attr();
    logic [31:0] v;
    logic [31:0] d = 32'hF12345D9;
    wr(3'd0, d); rd(3'd0, v); chk("R3 attr readback", v, d);
    chk("R3 periph addr", periph_addr_o, {d[31:28], 6'b0, d[27:8], 2'b00});
  endtask

  task automatic t_slot_regs();
    logic [31:0] v;
    wr(3'd4, 32'h00001003); rd(3'd4, v); chk("R4 addr align", v, 32'h00001000);
    wr(3'd7, 32'h0000FFFF); rd(3'd7, v); chk("R4 count width", v, 32'h00001FFF);
  endtask

  task automatic t_xfer();
    logic [31:0] v;
    logic [31:0] exp_adr [7] = '{32'h2000, 32'h2001, 32'h2002,
                                 32'h3000, 32'h3001, 32'h3002, 32'h3003};
    wr(3'd0, 32'h01);
    wr(3'd4, 32'h2000); wr(3'd5, 32'd3);
    wr(3'd6, 32'h3000); wr(3'd7, 32'd4);
    dev_req_i = 1'b1; mem_gnt_i = 1'b1;
    wr(3'd1, 32'h50);
    chk("R10 no req without run", {31'b0, mem_req_o}, 32'h0);
    wr(3'd1, 32'h03);
    for (int i = 0; i < 7; i++) begin
      chk("R7 gapless ack", {31'b0, dev_ack_o}, 32'h1);
      chk("R12 mem addr", mem_addr_o, exp_adr[i]);
      chk("R12 mem we", {31'b0, mem_we_o}, 32'h1);
      @(negedge clk_i);
    end
    chk("R6 idle after both", {31'b0, mem_req_o}, 32'h0);
    rd(3'd3, v); chk("R6 status after both", v, 32'h2B);
    chk("R8 irq on done", {31'b0, irq_o}, 32'h1);
    rd(3'd5, v); chk("R5 count A zero", v, 32'h0);
    rd(3'd4, v); chk("R5 addr A end", v, 32'h2003);
    rd(3'd6, v); chk("R5 addr B end", v, 32'h3004);
    wr(3'd2, 32'h28);
    chk("R8 irq cleared", {31'b0, irq_o}, 32'h0);
    rd(3'd3, v); chk("R2 status after ack", v, 32'h03);
  endtask

  task automatic t_wide();
    logic [31:0] v;
    wr(3'd2, 32'h01);
    wr(3'd0, 32'h08);
    wr(3'd4, 32'h4000); wr(3'd5, 32'd5);
    wr(3'd1, 32'h10);
    wr(3'd1, 32'h01);
    for (int i = 0; i < 3; i++) begin
      chk("R5 wide ack", {31'b0, dev_ack_o}, 32'h1);
      chk("R5 wide addr", mem_addr_o, 32'h4000 + 32'(2*i));
      chk("R12 mem we low", {31'b0, mem_we_o}, 32'h0);
      @(negedge clk_i);
    end
    chk("R5 wide stop", {31'b0, mem_req_o}, 32'h0);
    rd(3'd3, v); chk("R6 status wide", v, 32'h8B);
    rd(3'd5, v); chk("R5 wide count saturates", v, 32'h0);
    rd(3'd4, v); chk("R5 wide addr end", v, 32'h4006);
    wr(3'd2, 32'h7F);
    rd(3'd3, v); chk("R2 bit7 clear ignored", v, 32'h80);
  endtask

  task automatic t_pause();
    logic [31:0] v;
    wr(3'd0, 32'h01);
    wr(3'd6, 32'h5000); wr(3'd7, 32'd10);
    wr(3'd1, 32'h40);
    wr(3'd1, 32'h01);
    chk("R9 beat 0", mem_addr_o, 32'h5000); @(negedge clk_i);
    chk("R9 beat 1", mem_addr_o, 32'h5001); @(negedge clk_i);
    wr(3'd2, 32'h01); // beat at 0x5002 is taken on this edge
    chk("R9 paused no req", {31'b0, mem_req_o}, 32'h0);
    rd(3'd7, v); chk("R9 count kept", v, 32'd7);
    repeat (3) @(negedge clk_i);
    rd(3'd7, v); chk("R9 count still kept", v, 32'd7);
    rd(3'd3, v); chk("R9 start kept", v, 32'hC0);
    wr(3'd1, 32'h01);
    chk("R9 resume req", {31'b0, mem_req_o}, 32'h1);
    chk("R9 resume addr", mem_addr_o, 32'h5003);
    wr(3'd2, 32'h7F);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(3'd7, 32'd0);
    wr(3'd1, 32'h40);
    wr(3'd1, 32'h01);
    chk("R13 no req on zero", {31'b0, mem_req_o}, 32'h0);
    chk("R13 no ack on zero", {31'b0, dev_ack_o}, 32'h0);
    @(negedge clk_i);
    rd(3'd3, v); chk("R13 zero slot finished", v, 32'h21);
    chk("R8 no irq without ie", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    wr(3'd2, 32'h7F);
    wr(3'd4, 32'h6000); wr(3'd5, 32'd8);
    mem_err_i = 1'b1;
    wr(3'd1, 32'h10);
    wr(3'd1, 32'h03);
    chk("R11 err beat", {31'b0, dev_ack_o}, 32'h1);
    @(negedge clk_i);
    mem_err_i = 1'b0;
    rd(3'd3, v); chk("R11 error stops", v, 32'h16);
    chk("R11 no req after error", {31'b0, mem_req_o}, 32'h0);
    chk("R8 irq on error", {31'b0, irq_o}, 32'h1);
    rd(3'd5, v); chk("R11 count after err beat", v, 32'd7);
    wr(3'd2, 32'h04);
    chk("R8 irq after err clear", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_csr();
    t_attr();
    t_slot_regs();
    t_xfer();
    t_wide();
    t_pause();
    t_zero();
    t_error();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule